// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits in front of a small shared memory and gives several requesters an atomic read-modify-write primitive. A requester issues a linked load to read a word and claim it. Later it issues a conditional store to the same word. The conditional store takes effect only if nobody has written that word in between. The requester learns the outcome from a 1 (written) or 0 (dropped) in the response. It retries the pair until it sees a 1. The pair then acts as an atomic exchange or test-and-set on the word.

Every requester has one reservation slot holding a valid flag and a word address. All requesters share one port into a word-addressed internal array. A fixed-priority arbiter accepts one request per cycle. A request that is not accepted stays presented by its requester until it is granted. The response for an accepted request appears one cycle later on that requester's response strobe. The read data or status is on a shared data bus.

Top module: `llsc_monitor`

## Requirements
- R1: Each cycle at most one request is granted, and it is the valid request with the lowest requester index. `reqGrant` is combinational and one-hot or zero.
- R2: Exactly one cycle after a grant, `rspValid` carries the same one-hot pattern. It is zero in every cycle that follows a cycle without a grant.
- R3: Operation code 2'b00 (plain load) returns the addressed word. Code 2'b01 (plain store) writes the word and returns a response data value of 0.
- R4: Code 2'b10 (linked load) returns the addressed word and sets that requester's reservation to this address. Any earlier reservation of the same requester is replaced.
- R5: Code 2'b11 (conditional store) succeeds when the requester holds a valid reservation for exactly this address. On success it writes the word and returns data value 1.
- R6: A conditional store with no valid reservation, or with a reservation for another address, fails. It leaves memory unchanged, returns 0, and leaves all reservations as they were.
- R7: Every memory write clears every reservation, of any requester, whose address equals the written address. This covers plain stores and successful conditional stores, including the writer's own reservation. Reservations for other addresses are unaffected.
- R8: Reset clears all reservations and all response strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | NUM_REQ | Request present, one bit per requester |
| reqOp | input | 2*NUM_REQ | Operation code per requester, 2 bits each |
| reqAddr | input | ADDR_W*NUM_REQ | Word address per requester |
| reqData | input | DATA_W*NUM_REQ | Store data per requester |
| reqGrant | output | NUM_REQ | Request accepted this cycle |
| rspValid | output | NUM_REQ | Response strobe, one cycle after the grant |
| rspData | output | DATA_W | Read word, 0 for a plain store, or conditional status |

## Verification
The bench builds the block with its defaults: four requesters and a 64-word memory of 32-bit words. Four requesters are enough to exercise all of the following:
- a full priority chain in which lower-priority requesters wait several cycles;
- two requesters reserving the same word, where one successful conditional store defeats the other;
- a third requester breaking a reservation with a plain store.

With 64 words, every location can be preloaded and predicted by the reference model.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LINK  = 2'b10,
    OP_COND  = 2'b11
  } opKind_e;

  typedef struct packed {
    logic memWrite;
    logic statusRsp;
    logic statusBit;
  } dpStrobe_t;
endpackage

// File: rtl/llsc_ctrl.sv
module llsc_ctrl
  import llsc_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_REQ-1:0]         reqValid,
  input  logic [2*NUM_REQ-1:0]       reqOp,
  input  logic [ADDR_W*NUM_REQ-1:0]  reqAddr,
  input  logic [DATA_W*NUM_REQ-1:0]  reqData,
  output logic [NUM_REQ-1:0]         reqGrant,
  output logic [ADDR_W-1:0]          selAddr,
  output logic [DATA_W-1:0]          selData,
  output dpStrobe_t                  strobe
);
  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

  logic [IDX_W-1:0]  selIdx;
  logic              anyReq;
  opKind_e           selOp;
  logic              linkHit;
  logic [NUM_REQ-1:0] resValid;
  logic [ADDR_W-1:0] resAddr [NUM_REQ];

  // fixed priority: lowest index wins
  always_comb begin
    reqGrant = '0;
    selIdx   = '0;
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (reqValid[i]) begin
        reqGrant = '0;
        reqGrant[i] = 1'b1;
        selIdx = IDX_W'(i);
      end
    end
  end

  assign anyReq  = |reqValid;
  assign selOp   = opKind_e'(reqOp[selIdx*2 +: 2]);
  assign selAddr = reqAddr[selIdx*ADDR_W +: ADDR_W];
  assign selData = reqData[selIdx*DATA_W +: DATA_W];
  assign linkHit = resValid[selIdx] && (resAddr[selIdx] == selAddr);

  always_comb begin
    strobe.memWrite  = anyReq && ((selOp == OP_STORE) || (selOp == OP_COND && linkHit));
    strobe.statusRsp = anyReq && (selOp == OP_COND);
    strobe.statusBit = linkHit;
  end

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_res
    always_ff @(posedge clk) begin
      if (rst) begin
        resValid[i] <= 1'b0;
        resAddr[i]  <= '0;
      end else if (reqGrant[i] && selOp == OP_LINK) begin
        resValid[i] <= 1'b1;
        resAddr[i]  <= selAddr;
      end else if (strobe.memWrite && resAddr[i] == selAddr) begin
        resValid[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/llsc_datapath.sv
module llsc_datapath
  import llsc_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] reqGrant,
  input  logic [ADDR_W-1:0]  selAddr,
  input  logic [DATA_W-1:0]  selData,
  input  dpStrobe_t          strobe,
  output logic [NUM_REQ-1:0] rspValid,
  output logic [DATA_W-1:0]  rspData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] memArr [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.memWrite) memArr[selAddr] <= selData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid <= '0;
      rspData  <= '0;
    end else begin
      rspValid <= reqGrant;
      if (|reqGrant) begin
        if (strobe.statusRsp)     rspData <= DATA_W'(strobe.statusBit);
        else if (strobe.memWrite) rspData <= '0;
        else                      rspData <= memArr[selAddr];
      end
    end
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NUM_REQ   = 4,
  parameter int MEM_DEPTH = 64,
  parameter int DATA_W    = 32,
  localparam int ADDR_W   = $clog2(MEM_DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_REQ-1:0]         reqValid,
  input  logic [2*NUM_REQ-1:0]       reqOp,
  input  logic [ADDR_W*NUM_REQ-1:0]  reqAddr,
  input  logic [DATA_W*NUM_REQ-1:0]  reqData,
  output logic [NUM_REQ-1:0]         reqGrant,
  output logic [NUM_REQ-1:0]         rspValid,
  output logic [DATA_W-1:0]          rspData
);
  logic [ADDR_W-1:0] selAddr;
  logic [DATA_W-1:0] selData;
  dpStrobe_t         strobe;

  llsc_ctrl #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .reqGrant(reqGrant),
    .selAddr(selAddr), .selData(selData), .strobe(strobe)
  );

  llsc_datapath #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .reqGrant(reqGrant), .selAddr(selAddr),
    .selData(selData), .strobe(strobe), .rspValid(rspValid), .rspData(rspData)
  );
endmodule

// File: rtl/llsc_checker.sv
module llsc_checker #(
  parameter int NUM_REQ = 4,
  parameter int DATA_W  = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_REQ-1:0]   reqValid,
  input logic [2*NUM_REQ-1:0] reqOp,
  input logic [NUM_REQ-1:0]   reqGrant,
  input logic [NUM_REQ-1:0]   rspValid,
  input logic [DATA_W-1:0]    rspData
);
  logic condGranted;
  logic storeGranted;

  always_comb begin
    condGranted  = 1'b0;
    storeGranted = 1'b0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (reqGrant[i] && reqOp[2*i +: 2] == 2'b11) condGranted = 1'b1;
      if (reqGrant[i] && reqOp[2*i +: 2] == 2'b01) storeGranted = 1'b1;
    end
  end

  assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(reqGrant) && ((reqGrant & ~reqValid) == '0));

  assert_top_priority_R1: assert property (@(posedge clk) disable iff (rst)
    reqValid[0] |-> reqGrant[0]);

  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (rst)
    (reqGrant != '0) |=> (rspValid == $past(reqGrant)));

  assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (reqGrant == '0) |=> (rspValid == '0));

  assert_store_zero_R3: assert property (@(posedge clk) disable iff (rst)
    storeGranted |=> (rspData == '0));

  assert_status_bit_R5: assert property (@(posedge clk) disable iff (rst)
    condGranted |=> (rspData[DATA_W-1:1] == '0));
endmodule

bind llsc_monitor llsc_checker #(.NUM_REQ(NUM_REQ), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqOp(reqOp),
  .reqGrant(reqGrant), .rspValid(rspValid), .rspData(rspData)
);

// File: tb/llsc_monitor_test.sv
`timescale 1ns/1ps
module llsc_monitor_test;
  localparam int N  = 4;
  localparam int AW = 6;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]    reqValid = '0;
  logic [2*N-1:0]  reqOp = '0;
  logic [AW*N-1:0] reqAddr = '0;
  logic [DW*N-1:0] reqData = '0;
  logic [N-1:0]    reqGrant;
  logic [N-1:0]    rspValid;
  logic [DW-1:0]   rspData;

  int tests = 0;
  int fails = 0;

  // reference model state
  int unsigned mdlMem [64];
  bit          mdlResV [N];
  int          mdlResA [N];

  always #4 clk = ~clk;

  llsc_monitor uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .reqGrant(reqGrant),
    .rspValid(rspValid), .rspData(rspData)
  );

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input int r, input int op, input int a, input int unsigned d);
    reqValid[r] = 1'b1;
    reqOp[r*2 +: 2] = 2'(op);
    reqAddr[r*AW +: AW] = AW'(a);
    reqData[r*DW +: DW] = d;
  endtask

  // one clock: starts and ends at a falling edge
  task automatic cycle(input string tag);
    int g;
    int op;
    int a;
    int unsigned d;
    int unsigned expData;
    logic [N-1:0] expGrant;
    string t;
    #1;
    g = -1;
    for (int i = N - 1; i >= 0; i--) if (reqValid[i]) g = i;
    expGrant = (g < 0) ? '0 : N'(1 << g);
    check("R1 grant", reqGrant, expGrant);
    expData = 0;
    t = tag;
    if (g >= 0) begin
      op = int'(reqOp[g*2 +: 2]);
      a  = int'(reqAddr[g*AW +: AW]);
      d  = reqData[g*DW +: DW];
      case (op)
        0: begin expData = mdlMem[a]; if (t == "") t = "R3 load"; end
        1: begin
          mdlMem[a] = d;
          for (int i = 0; i < N; i++) if (mdlResA[i] == a) mdlResV[i] = 0;
          if (t == "") t = "R3 store";
        end
        2: begin
          expData = mdlMem[a]; mdlResV[g] = 1; mdlResA[g] = a;
          if (t == "") t = "R4 linked load";
        end
        default: begin
          if (mdlResV[g] && mdlResA[g] == a) begin
            mdlMem[a] = d;
            for (int i = 0; i < N; i++) if (mdlResA[i] == a) mdlResV[i] = 0;
            expData = 1;
            if (t == "") t = "R5 cond pass";
          end else if (t == "") t = "R6 cond fail";
        end
      endcase
    end
    @(posedge clk);
    #2;
    check("R2 rspValid", rspValid, expGrant);
    if (g >= 0) begin
      check(t, rspData, expData);
      reqValid[g] = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1;
    reqValid = '0;
    for (int i = 0; i < N; i++) mdlResV[i] = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R8 rspValid after reset", rspValid, 0);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin mdlResV[i] = 0; mdlResA[i] = 0; end
    @(negedge clk);
    doReset();
    check("R8 grant idle", reqGrant, 0);

    // preload every word
    for (int k = 0; k < 64; k++) begin
      put(0, 1, k, 32'h100 + k * 3);
      cycle("R3 preload store");
    end
    put(2, 0, 5, 0);  cycle("R3 load word 5");
    put(3, 0, 63, 0); cycle("R3 load word 63");

    // link then conditional store succeeds
    put(1, 2, 10, 0);          cycle("R4 link word 10");
    put(1, 3, 10, 32'hAAAA);   cycle("R5 cond store pass");
    put(1, 0, 10, 0);          cycle("R5 word written");
    put(1, 3, 10, 32'hBBBB);   cycle("R7 own reservation cleared");
    put(1, 0, 10, 0);          cycle("R6 word kept");

    // no reservation
    put(3, 3, 20, 32'h1234);   cycle("R6 cond without link");
    put(3, 0, 20, 0);          cycle("R6 memory unchanged");

    // two links broken by a third requester's plain store
    put(0, 2, 7, 0);           cycle("R4 link r0");
    put(2, 2, 7, 0);           cycle("R4 link r2");
    put(3, 1, 7, 32'h77);      cycle("R7 plain store");
    put(0, 3, 7, 32'h1);       cycle("R7 r0 loses");
    put(2, 3, 7, 32'h2);       cycle("R7 r2 loses");
    put(2, 0, 7, 0);           cycle("R7 word holds store");

    // replacement of reservation
    put(1, 2, 8, 0);           cycle("R4 link 8");
    put(1, 2, 9, 0);           cycle("R4 link 9 replaces");
    put(1, 3, 8, 32'h88);      cycle("R4 old address fails");
    put(1, 3, 9, 32'h99);      cycle("R4 new address passes");

    // unrelated write keeps reservation; wrong address fails
    put(2, 2, 11, 0);          cycle("R4 link 11");
    put(0, 1, 12, 32'hC);      cycle("R3 store other word");
    put(2, 3, 13, 32'hD);      cycle("R6 address mismatch");
    put(2, 3, 11, 32'hE);      cycle("R7 other address untouched");

    // contention: all four at once
    put(0, 0, 1, 0); put(1, 0, 2, 0); put(2, 0, 3, 0); put(3, 0, 4, 0);
    while (reqValid != '0) cycle("R1 held loads");
    cycle("R2 idle");

    // same word linked by two, both conditional stores arrive together
    put(0, 2, 30, 0);          cycle("R4 link r0 30");
    put(1, 2, 30, 0);          cycle("R4 link r1 30");
    put(0, 3, 30, 32'h5A); put(1, 3, 30, 32'hA5);
    cycle("R5 r0 wins");
    cycle("R7 r1 defeated");
    put(1, 0, 30, 0);          cycle("R7 word from r0");

    // reset drops reservations
    put(3, 2, 40, 0);          cycle("R4 link before reset");
    doReset();
    put(3, 3, 40, 32'hF0);     cycle("R8 cond after reset");
    put(3, 0, 40, 0);          cycle("R8 word unchanged");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule